// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Decoder

This block listens to the two-wire clock and data bus of a PS/2 mouse and turns each three-byte movement report into decoded fields. The mouse drives the clock; the block samples data when the clock falls. Each frame is 11 bits: a low start bit, eight data bits least significant first, an odd parity bit and a high stop bit. Three frames in a row form one report: first a status byte, then an X byte, then a Y byte.

The status byte carries the sign bits, the overflow flags and the button states. The block combines each sign bit with its byte into a 9-bit two's-complement delta. When the third frame of a good report arrives, it presents the fields with a single-cycle valid pulse. The fields then hold until the next good report. A bad frame discards the report in progress and raises an error pulse. A long silence on the bus resets the frame and byte position, so the next frame is taken as the start of a new report. The block only receives; it never drives the bus.

Top module: `ps2m_decoder`

## Requirements
- R1: After a synchronous active-low reset, `pkt_valid` and `pkt_err` are 0 and `dx`, `dy` and all flag and button outputs are 0.
- R2: A frame is sampled on falling edges of `ps2_clk_i`: bit 0 is the start bit (must be 0), bits 1 to 8 are the data byte LSB first, bit 9 is parity (the 9 bits from data through parity must have an odd count of ones) and bit 10 is the stop bit (must be 1).
- R3: `dx` equals {status bit 4, X byte} and `dy` equals {status bit 5, Y byte}, read as 9-bit two's complement, where a sign bit of 1 means negative.
- R4: `btn_l`, `btn_r` and `btn_m` equal status bits 0, 1 and 2.
- R5: `ovf_x` and `ovf_y` equal status bits 6 and 7.
- R6: Each good report produces exactly one `pkt_valid` pulse lasting one clock cycle. The output fields change only in the cycle of that pulse.
- R7: A byte taken as a status byte whose bit 3 is 0 is dropped without an error, and the next byte is taken as a candidate status byte.
- R8: A parity error in any frame discards the report in progress, gives a one-cycle `pkt_err` pulse, gives no `pkt_valid`, and leaves the output fields unchanged.
- R9: A start-bit or stop-bit error is handled in the same way as a parity error.
- R10: If more than `GAP_CYCLES` clock cycles pass after a falling edge of `ps2_clk_i` with no further falling edge while a report is partly received, the partial report is dropped silently and the next frame is taken as a status byte.
- R11: The same silence in the middle of a frame drops the bits collected so far, so the next falling edge is taken as a start bit.
- R12: Reports sent back to back with short gaps between frames are each decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ps2_clk_i | input | 1 | Bus clock from the mouse (asynchronous, high when idle) |
| ps2_dat_i | input | 1 | Bus data from the mouse (asynchronous, high when idle) |
| pkt_valid | output | 1 | One-cycle pulse when a good report has been decoded |
| dx | output | 9 | Signed X displacement; positive means right |
| dy | output | 9 | Signed Y displacement; positive means up |
| ovf_x | output | 1 | X magnitude overflow flag |
| ovf_y | output | 1 | Y magnitude overflow flag |
| btn_l | output | 1 | Left button pressed |
| btn_r | output | 1 | Right button pressed |
| btn_m | output | 1 | Middle button pressed |
| pkt_err | output | 1 | One-cycle pulse when a frame fails its start, stop or parity check |

## Verification
The assertions check properties that must hold on every cycle:
- the valid pulse lasts one cycle and never coincides with an error;
- the output fields change only together with a valid pulse;
- a byte is accepted only one cycle after a falling edge;
- the frame and byte counters stay in range;
- an accepted status byte always has its marker bit set.

The correct mapping of sign, overflow and button bits needs the bench scenarios. So do the dropping of unmarked bytes, the recovery after bad frames, and the silent resets after a mid-frame or mid-report silence. Each of these depends on a specific bit sequence driven on the bus.

// File: rtl/ps2m_pkg.sv
// ps2m_pkg: constants and types shared by the mouse report decoder.
// Assumes an 11-bit frame and a three-byte report with the status byte first.
package ps2m_pkg;

    localparam int FRAME_BITS = 11;

    // Status byte bit positions.
    localparam int ST_BTN_L = 0;
    localparam int ST_BTN_R = 1;
    localparam int ST_BTN_M = 2;
    localparam int ST_MARK  = 3;
    localparam int ST_SGN_X = 4;
    localparam int ST_SGN_Y = 5;
    localparam int ST_OVF_X = 6;
    localparam int ST_OVF_Y = 7;

    typedef enum logic [1:0] {
        IDX_STAT = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } ps2m_idx_e;

    typedef struct packed {
        logic [8:0] dx;
        logic [8:0] dy;
        logic       ovf_x;
        logic       ovf_y;
        logic       btn_l;
        logic       btn_r;
        logic       btn_m;
    } ps2m_report_t;

endpackage

// File: rtl/ps2m_sync.sv
// ps2m_sync: multi-stage synchronizer for the asynchronous bus lines.
// Assumes the lines idle high, so every stage resets to 1.
module ps2m_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    // First stage captures the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '1;
        else        stage[0] <= d;
    end

    // Each later stage copies the stage before it.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '1;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/ps2m_frame_rx.sv
// ps2m_frame_rx: collects one 11-bit frame on falling bus-clock edges and checks
// its start, parity and stop bits. It also measures silence on the bus and gives
// a single pulse when GAP_CYCLES cycles pass with no falling edge.
// Assumes inputs already synchronized and GAP_CYCLES >= 2.
module ps2m_frame_rx
    import ps2m_pkg::*;
#(
    parameter int GAP_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_clk,
    input  logic       line_dat,
    output logic       byte_vld,
    output logic [7:0] byte_q,
    output logic       frame_err,
    output logic       gap_hit
);

    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
    localparam logic [GW-1:0] GAP_SAT  = GW'(GAP_CYCLES);
    localparam logic [CW-1:0] BIT_LAST = CW'(FRAME_BITS - 1);

    logic                  clk_d;
    logic                  fall;
    logic [CW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] sh;
    logic [FRAME_BITS-1:0] frame_n;
    logic [GW-1:0]         idle_cnt;
    logic                  last_bit;
    logic                  frame_ok;

    assign fall     = clk_d & ~line_clk;
    assign frame_n  = {line_dat, sh[FRAME_BITS-1:1]};
    assign last_bit = (bit_cnt == BIT_LAST);
    assign frame_ok = ~frame_n[0] & frame_n[FRAME_BITS-1] & (^frame_n[9:1]);
    assign gap_hit  = (idle_cnt == GAP_LAST) & ~fall;

    // Delayed copy of the bus clock, used to find falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_d <= 1'b1;
        else        clk_d <= line_clk;
    end

    // Silence counter: cleared by each falling edge, stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_cnt <= GAP_SAT;
        else if (fall)             idle_cnt <= '0;
        else if (idle_cnt != GAP_SAT) idle_cnt <= idle_cnt + 1'b1;
    end

    // Bit collection: shift in each sample, drop partial frames on silence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
        end else if (fall) begin
            sh      <= frame_n;
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end else if (gap_hit) begin
            bit_cnt <= '0;
        end
    end

    // Frame result: one pulse of byte or error after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
            byte_q    <= '0;
        end else begin
            byte_vld  <= fall & last_bit & frame_ok;
            frame_err <= fall & last_bit & ~frame_ok;
            if (fall & last_bit) byte_q <= frame_n[8:1];
        end
    end

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BIT_LAST); // R2
    AST_BYTE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(fall)); // R2
    AST_BYTE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_err)); // R9
    AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> !gap_hit); // R10

endmodule

// File: rtl/ps2m_packet.sv
// ps2m_packet: groups three accepted bytes into one report, aligned on the
// status marker bit, and unpacks the fields. A frame error or bus silence sends
// the byte position back to the status byte.
// Assumes byte_vld, frame_err and gap_hit never occur in the same cycle.
module ps2m_packet
    import ps2m_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_vld,
    input  logic [7:0]   byte_q,
    input  logic         frame_err,
    input  logic         gap_hit,
    output ps2m_report_t rpt,
    output logic         rpt_vld,
    output logic         rpt_err
);

    ps2m_idx_e  idx;
    logic [7:0] stat_q;
    logic [7:0] xb_q;

    // Byte sequencing and report output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= IDX_STAT;
            stat_q  <= '0;
            xb_q    <= '0;
            rpt     <= '0;
            rpt_vld <= 1'b0;
            rpt_err <= 1'b0;
        end else begin
            rpt_vld <= 1'b0;
            rpt_err <= 1'b0;
            if (frame_err) begin
                idx     <= IDX_STAT;
                rpt_err <= 1'b1;
            end else if (gap_hit) begin
                idx <= IDX_STAT;
            end else if (byte_vld) begin
                case (idx)
                    IDX_STAT: begin
                        if (byte_q[ST_MARK]) begin
                            stat_q <= byte_q;
                            idx    <= IDX_X;
                        end
                    end
                    IDX_X: begin
                        xb_q <= byte_q;
                        idx  <= IDX_Y;
                    end
                    IDX_Y: begin
                        rpt.dx    <= {stat_q[ST_SGN_X], xb_q};
                        rpt.dy    <= {stat_q[ST_SGN_Y], byte_q};
                        rpt.ovf_x <= stat_q[ST_OVF_X];
                        rpt.ovf_y <= stat_q[ST_OVF_Y];
                        rpt.btn_l <= stat_q[ST_BTN_L];
                        rpt.btn_r <= stat_q[ST_BTN_R];
                        rpt.btn_m <= stat_q[ST_BTN_M];
                        rpt_vld   <= 1'b1;
                        idx       <= IDX_STAT;
                    end
                    default: idx <= IDX_STAT;
                endcase
            end
        end
    end

    AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |=> !rpt_vld); // R6
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rpt) |-> rpt_vld); // R6
    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_vld && rpt_err)); // R8
    AST_ERR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_err |-> (idx == IDX_STAT)); // R8
    AST_STATUS_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != IDX_STAT) |-> stat_q[ST_MARK]); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx != 2'd3); // R7

endmodule

// File: rtl/ps2m_decoder.sv
// ps2m_decoder: top of the mouse report decoder. Synchronizes the bus, receives
// frames and unpacks three-byte reports into signed deltas, flags and buttons.
// Assumes a receive-only bus and a system clock much faster than the bus clock.
module ps2m_decoder
    import ps2m_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYCLES  = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       pkt_valid,
    output logic [8:0] dx,
    output logic [8:0] dy,
    output logic       ovf_x,
    output logic       ovf_y,
    output logic       btn_l,
    output logic       btn_r,
    output logic       btn_m,
    output logic       pkt_err
);

    logic [1:0]   line_s;
    logic         byte_vld;
    logic [7:0]   byte_q;
    logic         frame_err;
    logic         gap_hit;
    ps2m_report_t rpt;

    ps2m_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ps2_clk_i, ps2_dat_i}),
        .q     (line_s)
    );

    ps2m_frame_rx #(.GAP_CYCLES(GAP_CYCLES)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (line_s[1]),
        .line_dat  (line_s[0]),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .frame_err (frame_err),
        .gap_hit   (gap_hit)
    );

    ps2m_packet u_pkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .frame_err (frame_err),
        .gap_hit   (gap_hit),
        .rpt       (rpt),
        .rpt_vld   (pkt_valid),
        .rpt_err   (pkt_err)
    );

    assign dx    = rpt.dx;
    assign dy    = rpt.dy;
    assign ovf_x = rpt.ovf_x;
    assign ovf_y = rpt.ovf_y;
    assign btn_l = rpt.btn_l;
    assign btn_r = rpt.btn_r;
    assign btn_m = rpt.btn_m;

endmodule

// File: tb/ps2m_decoder_tb.sv
module ps2m_decoder_tb;

    localparam int HALF = 20;   // bus half period in system cycles
    localparam int FGAP = 60;   // idle between frames
    localparam int GAP  = 300;  // silence limit given to the design
    localparam int LONG = 500;  // silence longer than the limit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps2_clk = 1'b1;
    logic ps2_dat = 1'b1;
    logic       pkt_valid, pkt_err;
    logic [8:0] dx, dy;
    logic       ovf_x, ovf_y, btn_l, btn_r, btn_m;

    int n_chk = 0;
    int n_err = 0;
    int vld_cnt = 0;
    int err_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ps2m_decoder #(.SYNC_STAGES(2), .GAP_CYCLES(GAP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps2_clk_i (ps2_clk),
        .ps2_dat_i (ps2_dat),
        .pkt_valid (pkt_valid),
        .dx        (dx),
        .dy        (dy),
        .ovf_x     (ovf_x),
        .ovf_y     (ovf_y),
        .btn_l     (btn_l),
        .btn_r     (btn_r),
        .btn_m     (btn_m),
        .pkt_err   (pkt_err)
    );

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) vld_cnt++;
            if (pkt_err)   err_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par = 0,
                              input bit bad_start = 0, input bit bad_stop = 0,
                              input int nbits = 11);
        logic [10:0] bits;
        bits = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
        for (int i = 0; i < nbits; i++) begin
            ps2_dat = bits[i];
            cyc(HALF);
            ps2_clk = 1'b0;
            cyc(HALF);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        cyc(FGAP);
    endtask

    task automatic send_pkt(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
        send_frame(s);
        send_frame(x);
        send_frame(y);
    endtask

    task automatic check_fields(input string tag, input int edx, input int edy,
                                input int eflags);
        @(negedge clk);
        chk({tag, " dx"}, int'(dx), edx);
        chk({tag, " dy"}, int'(dy), edy);
        chk({tag, " flags"}, int'({ovf_y, ovf_x, btn_m, btn_r, btn_l}), eflags);
    endtask

    // R1: reset state.
    task automatic t_reset;
        @(negedge clk);
        chk("R1 pulses", int'({pkt_valid, pkt_err}), 0);
        check_fields("R1", 0, 0, 0);
    endtask

    // R2 R3 R4: positive deltas with left button.
    task automatic t_basic;
        int v0 = vld_cnt;
        send_pkt(8'h09, 8'h12, 8'h34);
        chk("R2 one report", vld_cnt - v0, 1);
        check_fields("R3 R4 positive", 9'h012, 9'h034, 5'b00001);
    endtask

    // R3 R4: negative deltas with right button.
    task automatic t_negative;
        int v0 = vld_cnt;
        send_pkt(8'h3A, 8'hF0, 8'h80);
        chk("R3 one report", vld_cnt - v0, 1);
        check_fields("R3 negative", 9'h1F0, 9'h180, 5'b00010);
    endtask

    // R5 R4: overflow flags and middle button.
    task automatic t_overflow;
        send_pkt(8'hCC, 8'hFF, 8'h01);
        check_fields("R5 overflow", 9'h0FF, 9'h001, 5'b11100);
    endtask

    // R7: unmarked leading byte dropped.
    task automatic t_align;
        int v0 = vld_cnt;
        int e0 = err_cnt;
        send_frame(8'h12);
        send_pkt(8'h09, 8'h05, 8'h06);
        chk("R7 reports", vld_cnt - v0, 1);
        chk("R7 errors", err_cnt - e0, 0);
        check_fields("R7", 9'h005, 9'h006, 5'b00001);
    endtask

    // R8: parity error in the X frame.
    task automatic t_parity;
        int v0 = vld_cnt;
        int e0 = err_cnt;
        send_frame(8'h3A);
        send_frame(8'h44, 1'b1);
        cyc(LONG);
        chk("R8 errors", err_cnt - e0, 1);
        chk("R8 reports", vld_cnt - v0, 0);
        check_fields("R8 held", 9'h005, 9'h006, 5'b00001);
        send_pkt(8'h0A, 8'h07, 8'h08);
        check_fields("R8 recover", 9'h007, 9'h008, 5'b00010);
    endtask

    // R9: start error on a status frame, then stop error on a Y frame.
    task automatic t_framing;
        int v0 = vld_cnt;
        int e0 = err_cnt;
        send_frame(8'h09, 1'b0, 1'b1);
        cyc(LONG);
        chk("R9 start err", err_cnt - e0, 1);
        send_frame(8'h09);
        send_frame(8'h11);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        cyc(LONG);
        chk("R9 stop err", err_cnt - e0, 2);
        chk("R9 reports", vld_cnt - v0, 0);
        check_fields("R9 held", 9'h007, 9'h008, 5'b00010);
    endtask

    // R10: silence between frames drops the partial report.
    task automatic t_gap_report;
        int v0 = vld_cnt;
        int e0 = err_cnt;
        send_frame(8'h0C);
        send_frame(8'h55);
        cyc(LONG);
        send_pkt(8'h09, 8'h21, 8'h22);
        chk("R10 reports", vld_cnt - v0, 1);
        chk("R10 errors", err_cnt - e0, 0);
        check_fields("R10", 9'h021, 9'h022, 5'b00001);
    endtask

    // R11: silence inside a frame drops the partial bits.
    task automatic t_gap_frame;
        int v0 = vld_cnt;
        int e0 = err_cnt;
        send_frame(8'h09);
        send_frame(8'hAA, 1'b0, 1'b0, 1'b0, 5);
        cyc(LONG);
        send_pkt(8'h0B, 8'h31, 8'h32);
        chk("R11 reports", vld_cnt - v0, 1);
        chk("R11 errors", err_cnt - e0, 0);
        check_fields("R11", 9'h031, 9'h032, 5'b00011);
    endtask

    // R12: back-to-back reports.
    task automatic t_back_to_back;
        int v0 = vld_cnt;
        send_pkt(8'h19, 8'hFE, 8'h03);
        send_pkt(8'h28, 8'h04, 8'hFD);
        chk("R12 reports", vld_cnt - v0, 2);
        check_fields("R12 last", 9'h004, 9'h1FD, 5'b00000);
    endtask

    initial begin
        cyc(5);
        t_reset();
        rst_n = 1'b1;
        cyc(5);
        t_basic();
        t_negative();
        t_overflow();
        t_align();
        t_parity();
        t_framing();
        t_gap_report();
        t_gap_frame();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule